// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host start read and write transactions on a two-wire PHY management bus. It runs from the fast system clock. It derives the management clock (MDC) from that clock with a coded divider and shifts each transaction out as a fixed 64-bit frame on the data line (MDIO). During a read, the block releases the line and captures the 16 bits the PHY sends back.

The host places the direction, PHY address, register address, write data and a 4-bit rate code on the command inputs, then pulses `start` for one cycle. `busy` stays high for the whole frame, and any further start pulse during that time has no effect. When `busy` falls, `rdData` holds the word returned by the most recent read. MDIO is driven through an output enable, so the pad can be tri-stated while the PHY owns the line.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 one bits on `mdioOut`, followed by a 0 bit and then a 1 bit.
- R2: After the start bits, the opcode is sent as 1,0 for a read (`cmdRead`=1) or 0,1 for a write (`cmdRead`=0).
- R3: After the opcode, `phyAddr` and then `regAddr` are sent, each 5 bits wide and MSB first. This makes frame bit indices 36..45.
- R4: The two turnaround bits are frame indices 46..47. A write drives them as 1,0. A read drives index 46 as 1, then holds `mdioOe` low from index 47 to the end of the frame. A write keeps `mdioOe` high for all 64 bits.
- R5: A write sends `wrData` MSB first in frame indices 48..63.
- R6: A read samples `mdioIn` on each MDC rising edge of indices 48..63, MSB first. The word appears on `rdData` in the same cycle that `busy` falls, and it is held until the next read completes. Writes leave `rdData` unchanged.
- R7: Each bit lasts D system clocks, with MDC low for the first D/2 and high for the second D/2. D is 42 for rate code 0000, 16 for code 0010 and 26 for code 0011.
- R8: All other rate codes, including 0001, 0100..0111 and 1xxx, give D = 42.
- R9: `busy` rises on the clock edge that sees `start` while idle and falls exactly 64·D cycles later. A `start` pulse while `busy` is high starts nothing and does not alter the frame in progress.
- R10: After reset, and whenever idle, `busy`, `mdc` and `mdioOe` are low and `rdData` is 0 after reset.
- R11: The rate code is captured only at the start edge; later changes to `rangeCode` do not affect the running frame.
- R12: During a frame, `mdioOut` changes only on the clock edge where MDC falls, or at the frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transaction request |
| cmdRead | input | 1 | 1 = read, 0 = write |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Data for a write |
| rangeCode | input | 4 | MDC divide selection |
| busy | output | 1 | Transaction in progress |
| rdData | output | 16 | Last word read from the PHY |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line input value |

## Verification
The assertions assume three things about the inputs: `start` is a synchronous pulse, the command fields are stable on the start edge, and `mdioIn` is only meaningful in the read data window. The bench drives every input on the falling system-clock edge and holds the command fields until the start edge has passed. Its PHY model changes `mdioIn` only right after it sees an MDC rise, so the value is always settled half a bit period before the next sample. Stray start pulses and rate-code changes are injected in the middle of frames to exercise the rules on ignored starts and on capturing the rate code at the start edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int CODE_W  = 4;
  localparam int PRE_LEN = 32;

  typedef struct packed {
    logic load;      // capture command into frame register
    logic shiftOut;  // advance to next outgoing bit (MDC falling)
    logic sampleIn;  // capture one read bit (MDC rising)
    logic commit;    // publish completed read word
  } mdio_strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl #(
  parameter int CODE_W    = mdio_pkg::CODE_W,
  parameter int DATA_W    = mdio_pkg::DATA_W,
  parameter int FRAME_LEN = 64,
  parameter int DIV_SLOW  = 42,
  parameter int DIV_MID   = 26,
  parameter int DIV_FAST  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       isReadReq,
  input  logic [CODE_W-1:0]          rangeCode,
  output logic                       busy,
  output logic                       mdc,
  output logic                       mdioOe,
  output mdio_pkg::mdio_strobe_t     stb
);
  localparam int IDX_W       = $clog2(FRAME_LEN);
  localparam int HALF_W      = $clog2(DIV_SLOW);
  localparam int DATA_IDX    = FRAME_LEN - DATA_W;
  localparam int RELEASE_IDX = DATA_IDX - 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(FRAME_LEN - 1);
  localparam logic [HALF_W-1:0] HALF_SLOW = HALF_W'(DIV_SLOW / 2 - 1);
  localparam logic [HALF_W-1:0] HALF_MID  = HALF_W'(DIV_MID / 2 - 1);
  localparam logic [HALF_W-1:0] HALF_FAST = HALF_W'(DIV_FAST / 2 - 1);

  logic [HALF_W-1:0] halfCnt, halfLim;
  logic [IDX_W-1:0]  bitIdx;
  logic              isRead;
  logic              launch, halfDone, lastBit;

  function automatic logic [HALF_W-1:0] pickHalf(input logic [CODE_W-1:0] code);
    case (code)
      CODE_W'(0): pickHalf = HALF_SLOW;
      CODE_W'(2): pickHalf = HALF_FAST;
      CODE_W'(3): pickHalf = HALF_MID;
      default:    pickHalf = HALF_SLOW;  // reserved codes fall back to slowest rate
    endcase
  endfunction

  always_comb begin
    launch       = start && !busy;
    halfDone     = busy && (halfCnt == halfLim);
    lastBit      = (bitIdx == LAST_IDX);
    stb.load     = launch;
    stb.sampleIn = halfDone && !mdc && isRead && (bitIdx >= IDX_W'(DATA_IDX));
    stb.shiftOut = halfDone && mdc && !lastBit;
    stb.commit   = halfDone && mdc && lastBit && isRead;
    mdioOe       = busy && !(isRead && (bitIdx >= IDX_W'(RELEASE_IDX)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      halfCnt <= '0;
      halfLim <= HALF_SLOW;
      bitIdx  <= '0;
      isRead  <= 1'b0;
    end else if (launch) begin
      busy    <= 1'b1;
      mdc     <= 1'b0;
      halfCnt <= '0;
      halfLim <= pickHalf(rangeCode);
      bitIdx  <= '0;
      isRead  <= isReadReq;
    end else if (busy) begin
      if (halfDone) begin
        halfCnt <= '0;
        mdc     <= !mdc;
        if (mdc) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  // R10: idle bus is quiet
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));
  // R7: half-period counter never overruns its limit
  p_half_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfCnt <= halfLim));
  // R8: only the three legal rates are ever in use
  p_legal_rate_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfLim == HALF_SLOW || halfLim == HALF_MID || halfLim == HALF_FAST));
  // R11: rate stays fixed for a whole frame
  p_rate_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(halfLim));
  // R9: a start during a frame does not re-latch the direction
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(isRead));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath #(
  parameter int ADDR_W    = mdio_pkg::ADDR_W,
  parameter int DATA_W    = mdio_pkg::DATA_W,
  parameter int PRE_LEN   = mdio_pkg::PRE_LEN,
  parameter int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mdio_pkg::mdio_strobe_t stb,
  input  logic                   isReadReq,
  input  logic [ADDR_W-1:0]      phyAddr,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic                   mdioIn,
  output logic                   mdioOut,
  output logic [DATA_W-1:0]      rdData
);
  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_BITS  = 2'b10;

  logic [FRAME_LEN-1:0] frame, loadVal;
  logic [DATA_W-1:0]    rdShift;

  always_comb begin
    loadVal = {{PRE_LEN{1'b1}}, SOF_BITS, (isReadReq ? OP_READ : OP_WRITE),
               phyAddr, regAddr, TA_BITS, (isReadReq ? {DATA_W{1'b0}} : wrData)};
    mdioOut = frame[FRAME_LEN-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame   <= {FRAME_LEN{1'b1}};
      rdShift <= '0;
      rdData  <= '0;
    end else begin
      if (stb.load)          frame   <= loadVal;
      else if (stb.shiftOut) frame   <= {frame[FRAME_LEN-2:0], 1'b0};
      if (stb.sampleIn)      rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (stb.commit)        rdData  <= rdShift;
    end
  end

  // R12: control never asks for two actions in one cycle
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.shiftOut, stb.sampleIn, stb.commit}));
  // R6: read result only moves on a commit
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(rdData));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int ADDR_W   = mdio_pkg::ADDR_W,
  parameter int DATA_W   = mdio_pkg::DATA_W,
  parameter int CODE_W   = mdio_pkg::CODE_W,
  parameter int PRE_LEN  = mdio_pkg::PRE_LEN,
  parameter int DIV_SLOW = 42,
  parameter int DIV_MID  = 26,
  parameter int DIV_FAST = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CODE_W-1:0] rangeCode,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  localparam int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;

  mdio_pkg::mdio_strobe_t stb;

  mdio_ctrl #(
    .CODE_W(CODE_W), .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN),
    .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .isReadReq(cmdRead),
    .rangeCode(rangeCode), .busy(busy), .mdc(mdc), .mdioOe(mdioOe), .stb(stb)
  );

  mdio_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN), .FRAME_LEN(FRAME_LEN)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .isReadReq(cmdRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .rdData(rdData)
  );

  // R12: data line holds while MDC is high
  p_mdio_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mdc) |=> (!mdc || $stable(mdioOut)));
  // R4: once released for a read, the line stays released until frame end
  p_release_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !mdioOe) |=> (!busy || !mdioOe));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        cmdRead = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rangeCode = '0;
  logic        busy, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench PHY / monitor state
  int          cyc = 0;
  int          riseCnt = 0;
  int          fallCyc0 = 0;
  int          fallCnt = 0;
  int          riseCyc [64];
  logic [63:0] outBits, oeBits;
  logic [15:0] phyData = '0;
  logic [15:0] lastRd = '0;
  logic        prevMdc = 1'b0;

  // rate codes -> {rw, code, phy, reg, wdata, phy read data}
  localparam logic [46:0] VEC [6] = '{
    {1'b0, 4'b0010, 5'h01, 5'h00, 16'hA5C3, 16'h0000},
    {1'b1, 4'b0011, 5'h1F, 5'h1E, 16'h0000, 16'h8001},
    {1'b1, 4'b0000, 5'h15, 5'h0A, 16'h0000, 16'h3C5A},
    {1'b0, 4'b0001, 5'h0A, 5'h15, 16'hFFFF, 16'h0000},
    {1'b1, 4'b0101, 5'h03, 5'h11, 16'h0000, 16'h7FFE},
    {1'b0, 4'b1111, 5'h10, 5'h01, 16'h0000, 16'h0000}
  };

  mdio_master dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdRead(cmdRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData), .rangeCode(rangeCode),
    .busy(busy), .rdData(rdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !prevMdc) begin
      if (riseCnt < 64) begin
        outBits[63-riseCnt] = mdioOut;
        oeBits[63-riseCnt]  = mdioOe;
        riseCyc[riseCnt]    = cyc;
      end
      riseCnt++;
      if (riseCnt >= 48 && riseCnt <= 63) mdioIn = phyData[63-riseCnt];
      else mdioIn = 1'b1;
    end
    if (!mdc && prevMdc) begin
      if (fallCnt == 0) fallCyc0 = cyc;
      fallCnt++;
    end
    prevMdc = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int expDiv(input logic [3:0] code);
    case (code)
      4'b0000: return 42;
      4'b0010: return 16;
      4'b0011: return 26;
      default: return 42;
    endcase
  endfunction

  task automatic runFrame(input logic rw, input logic [3:0] code, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd,
                          input logic [15:0] pd, input bit disturb);
    int div = expDiv(code);
    int n = 0;
    logic [63:0] expFrame, expOe;
    string rateReq;
    rateReq = disturb ? "R11" : ((code == 4'b0000 || code == 4'b0010 || code == 4'b0011) ? "R7" : "R8");
    expFrame = {32'hFFFF_FFFF, 2'b01, (rw ? 2'b10 : 2'b01), pa, ra, 2'b10, (rw ? 16'h0 : wd)};
    expOe    = rw ? 64'hFFFF_FFFF_FFFE_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    phyData = pd; riseCnt = 0; fallCnt = 0;
    cmdRead = rw; rangeCode = code; phyAddr = pa; regAddr = ra; wrData = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy rise", {63'b0, busy}, 64'd1);
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
      if (disturb && n == 200) begin
        start = 1'b1; cmdRead = !rw; phyAddr = ~pa; regAddr = ~ra; wrData = ~wd;
        rangeCode = (code == 4'b0000) ? 4'b0010 : 4'b0000;
      end
      if (disturb && n == 201) start = 1'b0;
    end
    check(n == 64 * div, "R9 busy length", 64'(n), 64'(64 * div));
    check(riseCnt == 64, "R9 bit count", 64'(riseCnt), 64'd64);
    check(outBits[63:30] == expFrame[63:30], "R1 preamble+start", 64'(outBits[63:30]), 64'(expFrame[63:30]));
    check(outBits[29:28] == expFrame[29:28], "R2 opcode", 64'(outBits[29:28]), 64'(expFrame[29:28]));
    check(outBits[27:18] == expFrame[27:18], "R3 addresses", 64'(outBits[27:18]), 64'(expFrame[27:18]));
    check(oeBits == expOe, "R4 output enable", oeBits, expOe);
    check(outBits[17] == 1'b1, "R4 first turnaround", 64'(outBits[17]), 64'd1);
    if (!rw) begin
      check(outBits[16] == 1'b0, "R4 second turnaround", 64'(outBits[16]), 64'd0);
      check(outBits[15:0] == wd, "R5 write data", 64'(outBits[15:0]), 64'(wd));
    end
    if (rw) lastRd = pd;
    check(rdData == lastRd, "R6 read data", 64'(rdData), 64'(lastRd));
    check(riseCyc[1] - riseCyc[0] == div, {rateReq, " bit period"},
          64'(riseCyc[1] - riseCyc[0]), 64'(div));
    check(riseCyc[63] - riseCyc[0] == 63 * div, {rateReq, " frame span"},
          64'(riseCyc[63] - riseCyc[0]), 64'(63 * div));
    check(fallCyc0 - riseCyc[0] == div / 2, "R7 high phase",
          64'(fallCyc0 - riseCyc[0]), 64'(div / 2));
    repeat (40) @(negedge clk);
    check(!busy && !mdc && !mdioOe, "R10 idle after frame (R9 no restart)",
          {61'b0, busy, mdc, mdioOe}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!busy && !mdc && !mdioOe, "R10 reset outputs", {61'b0, busy, mdc, mdioOe}, 64'd0);
    check(rdData == 16'h0, "R10 reset rdData", 64'(rdData), 64'd0);

    for (int i = 0; i < 6; i++) begin
      runFrame(VEC[i][46], VEC[i][45:42], VEC[i][41:37], VEC[i][36:32],
               VEC[i][31:16], VEC[i][15:0], 1'b0);
    end

    // R9/R11: disturbances mid-frame
    runFrame(1'b1, 4'b0011, 5'h05, 5'h02, 16'h0000, 16'hC0DE, 1'b1);
    runFrame(1'b0, 4'b0000, 5'h1A, 5'h07, 16'h1234, 16'h0000, 1'b1);
    runFrame(1'b0, 4'b0010, 5'h00, 5'h1F, 16'h8000, 16'h0000, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule